// File: doc/BRIEF.md
# Ternary Weight Dot-Product Engine

This block forms the dot product of a stream of signed 8-bit activations with a stream of ternary weights taking values -1, 0 and +1, without any multiplier. Each accepted beat carries one activation per lane and one 2-bit weight code per lane. Per lane, the weight code acts as a mask. An activation whose weight is +1 is routed into a positive sum, and one whose weight is -1 is routed into a negative sum. A lane with a zero weight contributes nothing.

The masked lanes are widened in two stages. Adjacent lanes are first summed in pairs at 16 bits. Pairs of pairs then feed a bank of 32-bit accumulators, kept separately for the positive and negative paths. When the programmed inner length K has been consumed, the engine folds all accumulators into one signed 32-bit result, positive minus negative, and presents it with a one-cycle valid pulse.

A caller pulses `start` with K while the engine is idle. It then streams K/16 beats, qualified by `in_valid`, and waits for `res_valid`. Fetching operands from memory, tiling over output rows and quantizing activations are left to the surrounding logic.

Top module: `ternary_dot_engine`

## Requirements
- R1: The weight for lane i sits at `wgt_data[2i+1:2i]`, so four weights fill each byte. Code 01 means +1 (bit 0 selects the positive path), code 10 means -1 (bit 1 selects the negative path), and code 00 means zero, which adds nothing to either sum.
- R2: Lane i's activation is the signed 8-bit value `act_data[8i+7:8i]`, and 16 lanes are processed per accepted beat.
- R3: `result` equals the sum of activations paired with +1 minus the sum of activations paired with -1, over every beat of the dot product, as a two's-complement 32-bit value.
- R4: Both accumulators are cleared when a start is accepted, so each dot product is independent of the one before it.
- R5: A beat is accepted only when `in_valid` is high while the engine runs. The remaining length drops by 16 per accepted beat, and the beat on which 16 or fewer elements remain is the last one. Idle gaps between beats do not change the result.
- R6: `busy` rises on the edge that accepts a start with nonzero K. On the first edge after the edge that accepts the final beat, `res_valid` is high for exactly one cycle, `result` holds the value and `busy` falls.
- R7: A start with K equal to 0 produces `res_valid` with `result` 0 on the next edge, and `busy` stays low.
- R8: A start pulse while `busy` is high is ignored and changes neither the length nor the result of the dot product in progress.
- R9: Code 11 is treated as zero and sets `code_err`. `code_err` holds until the next accepted start clears it.
- R10: After synchronous reset, `busy`, `res_valid`, `code_err` and `result` are all 0.
- R11: Beats presented while the engine is idle are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a dot product (taken only when idle) |
| k_len | input | 16 | Inner length K, sampled with start |
| in_valid | input | 1 | Activation and weight beat is present |
| act_data | input | 128 | 16 signed 8-bit activations |
| wgt_data | input | 32 | 16 packed 2-bit weight codes |
| busy | output | 1 | Dot product in progress |
| res_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Signed dot product |
| code_err | output | 1 | Reserved weight code seen in this dot product |

## Verification
The engine is driven with several kinds of stimulus:
- a single beat that mixes all three weight values;
- multi-beat random streams sent back to back and with idle gaps;
- all-positive and all-negative beats at the activation extremes 127 and -128, which expose wrong sign extension in the pair and group sums;
- all-zero weights, which must leave the sum untouched.

Further runs cover the control behaviour. Reserved codes check both masking and the sticky flag. A start during a run, beats while idle, and K of zero separate the control decisions from the arithmetic. A behavioural model compares busy, the valid strobe, the flag and the result on every cycle.

// File: rtl/ternary_pkg.sv
package ternary_pkg;
  typedef enum logic [1:0] {
    W_ZERO = 2'b00,
    W_POS  = 2'b01,
    W_NEG  = 2'b10,
    W_RSVD = 2'b11
  } wcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } state_e;
endpackage

// File: rtl/ternary_lane_mask.sv
// Splits each lane's activation onto the positive or negative path by its
// weight code; zero and reserved codes leave both paths at zero.
module ternary_lane_mask
  import ternary_pkg::*;
#(
  parameter int LANES = 16,
  parameter int ACT_W = 8
) (
  input  logic [LANES*ACT_W-1:0] act,
  input  logic [2*LANES-1:0]     wgt,
  output logic [LANES*ACT_W-1:0] pos_lanes,
  output logic [LANES*ACT_W-1:0] neg_lanes,
  output logic                   rsvd_any
);
  logic [LANES-1:0] rsvd_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wcode_e code;
    assign code = wcode_e'(wgt[2*i +: 2]);
    assign pos_lanes[i*ACT_W +: ACT_W] = (code == W_POS) ? act[i*ACT_W +: ACT_W] : '0;
    assign neg_lanes[i*ACT_W +: ACT_W] = (code == W_NEG) ? act[i*ACT_W +: ACT_W] : '0;
    assign rsvd_vec[i] = (code == W_RSVD);
  end

  assign rsvd_any = |rsvd_vec;
endmodule

// File: rtl/ternary_lane_widen.sv
// Two-stage widening: adjacent lanes to PAIR_W sums, pairs of pairs to
// ACC_W increments, one per accumulator slot.
module ternary_lane_widen #(
  parameter int LANES  = 16,
  parameter int ACT_W  = 8,
  parameter int PAIR_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic [LANES*ACT_W-1:0]   lanes,
  output logic [LANES/4*ACC_W-1:0] grp
);
  localparam int NPAIR = LANES / 2;
  localparam int NGRP  = LANES / 4;

  logic signed [PAIR_W-1:0] pair [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic signed [ACT_W-1:0] lo, hi;
    assign lo = lanes[(2*p)*ACT_W +: ACT_W];
    assign hi = lanes[(2*p+1)*ACT_W +: ACT_W];
    assign pair[p] = PAIR_W'(lo) + PAIR_W'(hi);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic signed [ACC_W-1:0] a, b;
    assign a = ACC_W'(pair[2*g]);
    assign b = ACC_W'(pair[2*g+1]);
    assign grp[g*ACC_W +: ACC_W] = a + b;
  end
endmodule

// File: rtl/ternary_dot_engine.sv
module ternary_dot_engine
  import ternary_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ACT_W  = 8,
  parameter int PAIR_W = 16,
  parameter int ACC_W  = 32,
  parameter int KLEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [KLEN_W-1:0]      k_len,
  input  logic                   in_valid,
  input  logic [LANES*ACT_W-1:0] act_data,
  input  logic [2*LANES-1:0]     wgt_data,
  output logic                   busy,
  output logic                   res_valid,
  output logic [ACC_W-1:0]       result,
  output logic                   code_err
);
  localparam int NACC = LANES / 4;
  localparam logic [KLEN_W-1:0] STEP = KLEN_W'(LANES);

  state_e            state;
  logic [KLEN_W-1:0] rem;

  logic [LANES*ACT_W-1:0] pos_lanes, neg_lanes;
  logic                   rsvd_hit;
  logic [NACC*ACC_W-1:0]  pos_inc, neg_inc;
  logic [ACC_W-1:0]       pos_acc [NACC];
  logic [ACC_W-1:0]       neg_acc [NACC];
  logic [ACC_W-1:0]       fold;

  logic take_start, take_beat;
  assign take_start = (state == ST_IDLE) && start;
  assign take_beat  = (state == ST_RUN) && in_valid;
  assign busy       = (state != ST_IDLE);

  ternary_lane_mask #(.LANES(LANES), .ACT_W(ACT_W)) u_mask (
    .act       (act_data),
    .wgt       (wgt_data),
    .pos_lanes (pos_lanes),
    .neg_lanes (neg_lanes),
    .rsvd_any  (rsvd_hit)
  );

  ternary_lane_widen #(.LANES(LANES), .ACT_W(ACT_W), .PAIR_W(PAIR_W), .ACC_W(ACC_W)) u_widen_pos (
    .lanes (pos_lanes),
    .grp   (pos_inc)
  );

  ternary_lane_widen #(.LANES(LANES), .ACT_W(ACT_W), .PAIR_W(PAIR_W), .ACC_W(ACC_W)) u_widen_neg (
    .lanes (neg_lanes),
    .grp   (neg_inc)
  );

  // Add-only accumulator slots, cleared on every accepted start
  for (genvar j = 0; j < NACC; j++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || take_start) begin
        pos_acc[j] <= '0;
        neg_acc[j] <= '0;
      end else if (take_beat) begin
        pos_acc[j] <= pos_acc[j] + pos_inc[j*ACC_W +: ACC_W];
        neg_acc[j] <= neg_acc[j] + neg_inc[j*ACC_W +: ACC_W];
      end
    end
  end

  // Single subtraction per slot, then horizontal fold
  always_comb begin
    fold = '0;
    for (int j = 0; j < NACC; j++) begin
      fold = fold + (pos_acc[j] - neg_acc[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rem       <= '0;
      res_valid <= 1'b0;
      result    <= '0;
      code_err  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            code_err <= 1'b0;
            if (k_len == '0) begin
              res_valid <= 1'b1;
              result    <= '0;
            end else begin
              rem   <= k_len;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (in_valid) begin
            if (rsvd_hit) code_err <= 1'b1;
            if (rem <= STEP) state <= ST_FIN;
            else             rem   <= rem - STEP;
          end
        end
        ST_FIN: begin
          result    <= fold;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ternary_dot_engine_chk.sv
module ternary_dot_engine_chk #(
  parameter int ACC_W  = 32,
  parameter int KLEN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [KLEN_W-1:0] k_len,
  input logic              busy,
  input logic              res_valid,
  input logic [ACC_W-1:0]  result,
  input logic              code_err
);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !res_valid && !code_err && result == '0));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid || $past(start && k_len == '0)));

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && k_len != '0) |=> busy);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && k_len == '0) |=> (res_valid && result == '0 && !busy));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> !code_err);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(code_err) || code_err);
endmodule

bind ternary_dot_engine ternary_dot_engine_chk #(.ACC_W(ACC_W), .KLEN_W(KLEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .k_len     (k_len),
  .busy      (busy),
  .res_valid (res_valid),
  .result    (result),
  .code_err  (code_err)
);

// File: tb/ternary_dot_engine_test.sv
`timescale 1ns/1ps
module ternary_dot_engine_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [15:0]  k_len = '0;
  logic         in_valid = 1'b0;
  logic [127:0] act_data = '0;
  logic [31:0]  wgt_data = '0;
  logic         busy, res_valid, code_err;
  logic [31:0]  result;

  ternary_dot_engine uut (
    .clk(clk), .rst(rst), .start(start), .k_len(k_len), .in_valid(in_valid),
    .act_data(act_data), .wgt_data(wgt_data), .busy(busy), .res_valid(res_valid),
    .result(result), .code_err(code_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_res = 0, last_res = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  bit m_busy, m_fin, m_valid, m_err;
  int m_rem, m_sum, m_result;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_fin = 0; m_valid = 0; m_err = 0; m_rem = 0; m_sum = 0; m_result = 0;
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (start) begin
          m_err = 0;
          if (k_len == 0) begin m_valid = 1; m_result = 0; end
          else begin m_busy = 1; m_fin = 0; m_rem = int'(k_len); m_sum = 0; end
        end
      end else if (m_fin) begin
        m_valid = 1; m_result = m_sum; m_busy = 0; m_fin = 0;
      end else if (in_valid) begin
        for (int l = 0; l < 16; l++) begin
          int a;
          a = int'($signed(act_data[8*l +: 8]));
          case (wgt_data[2*l +: 2])
            2'b01: m_sum += a;
            2'b10: m_sum -= a;
            2'b11: m_err = 1;
            default: ;
          endcase
        end
        if (m_rem <= 16) m_fin = 1; else m_rem -= 16;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(busy === m_busy, "R6 busy", busy, m_busy);
      check(res_valid === m_valid, "R6 res_valid", res_valid, m_valid);
      check(code_err === m_err, "R9 code_err", code_err, m_err);
      if (m_valid) check(int'(result) == m_result, "R3 result", int'(result), m_result);
      if (res_valid) begin last_res = int'(result); n_res++; end
    end
  end

  function automatic int beat_dot(input logic [127:0] a, input logic [31:0] w);
    int s = 0;
    for (int l = 0; l < 16; l++) begin
      if (w[2*l +: 2] == 2'b01) s += int'($signed(a[8*l +: 8]));
      if (w[2*l +: 2] == 2'b10) s -= int'($signed(a[8*l +: 8]));
    end
    return s;
  endfunction

  function automatic logic [127:0] rand_act();
    logic [127:0] v;
    for (int l = 0; l < 16; l++) v[8*l +: 8] = 8'($urandom_range(255));
    return v;
  endfunction

  function automatic logic [31:0] rand_wgt(input int maxcode);
    logic [31:0] v;
    for (int l = 0; l < 16; l++) v[2*l +: 2] = 2'($urandom_range(maxcode));
    return v;
  endfunction

  task automatic do_start(input int k);
    @(negedge clk); start = 1; k_len = 16'(k); in_valid = 0;
  endtask

  task automatic beat(input logic [127:0] a, input logic [31:0] w);
    @(negedge clk); start = 0; in_valid = 1; act_data = a; wgt_data = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); start = 0; in_valid = 0; end
  endtask

  task automatic wait_res(input int base, input string tag, input int exp);
    int guard = 0;
    while (n_res == base && guard < 40) begin @(negedge clk); #1; guard++; end
    check(n_res == base + 1, {tag, " result count"}, n_res, base + 1);
    check(last_res == exp, tag, last_res, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    int base, exp;
    logic [127:0] a;
    logic [31:0]  w;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R10 reset state
    check(!busy && !res_valid && !code_err && result == 0, "R10 reset", {busy, res_valid, code_err}, 0);

    // R1 single beat, lane codes cycle zero/+1/-1
    base = n_res; exp = 0;
    for (int l = 0; l < 16; l++) begin
      a[8*l +: 8] = 8'(l * 7 - 40);
      w[2*l +: 2] = 2'(l % 3);
    end
    exp = beat_dot(a, w);
    do_start(16); beat(a, w); idle(1);
    wait_res(base, "R1 mixed single beat", exp);

    // R2 R5 four random beats back to back
    base = n_res; exp = 0;
    do_start(64);
    for (int b = 0; b < 4; b++) begin
      a = rand_act(); w = rand_wgt(2); exp += beat_dot(a, w); beat(a, w);
    end
    idle(1);
    wait_res(base, "R2 random 64", exp);

    // R3 extremes: all +1 with 127, then R4 independent op all -1 with -128
    base = n_res;
    do_start(32); beat({16{8'sd127}}, {16{2'b01}}); beat({16{8'sd127}}, {16{2'b01}}); idle(1);
    wait_res(base, "R3 all plus max", 4064);
    base = n_res;
    do_start(32); beat({16{8'h80}}, {16{2'b10}}); beat({16{8'h80}}, {16{2'b10}}); idle(1);
    wait_res(base, "R4 cleared, all minus min", 4096);

    // R1 zero weights contribute nothing
    base = n_res;
    do_start(16); beat(rand_act(), '0); idle(1);
    wait_res(base, "R1 zero weights", 0);

    // R5 gaps between beats
    base = n_res; exp = 0;
    do_start(48);
    for (int b = 0; b < 3; b++) begin
      a = rand_act(); w = rand_wgt(2); exp += beat_dot(a, w); beat(a, w); idle(b + 1);
    end
    wait_res(base, "R5 gapped beats", exp);

    // R8 start while busy is ignored
    base = n_res; exp = 0;
    do_start(32);
    a = rand_act(); w = rand_wgt(2); exp += beat_dot(a, w); beat(a, w);
    @(negedge clk); in_valid = 0; start = 1; k_len = 16'd16;
    a = rand_act(); w = rand_wgt(2); exp += beat_dot(a, w); beat(a, w); idle(1);
    wait_res(base, "R8 start during run", exp);

    // R7 K of zero
    base = n_res;
    do_start(0); idle(1); #1;
    check(res_valid && result == 0 && !busy, "R7 zero length", {res_valid, busy}, 2);
    check(n_res == base + 1, "R7 result count", n_res, base + 1);

    // R9 reserved codes masked and flagged
    base = n_res; exp = 0;
    do_start(32);
    a = rand_act(); w = rand_wgt(3); w[1:0] = 2'b11; exp += beat_dot(a, w); beat(a, w);
    a = rand_act(); w = rand_wgt(2); exp += beat_dot(a, w); beat(a, w); idle(1);
    wait_res(base, "R9 reserved masked", exp);
    check(code_err == 1, "R9 flag set", code_err, 1);
    base = n_res;
    do_start(16); idle(1); #1;
    check(code_err == 0, "R9 flag cleared by start", code_err, 0);
    a = rand_act(); w = rand_wgt(2); beat(a, w); idle(1);
    wait_res(base, "R4 next op", beat_dot(a, w));

    // R11 beats while idle
    base = n_res;
    beat(rand_act(), rand_wgt(2)); beat(rand_act(), rand_wgt(2)); idle(4); #1;
    check(!busy, "R11 stays idle", busy, 0);
    check(n_res == base, "R11 no result", n_res, base);

    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule